// File: doc/BRIEF.md
# EDO DRAM Output-Enable Controller

This block sits on the device side of an extended-data-out DRAM and decides, one reference-clock cycle at a time, whether the eight data-pin drivers are on. It watches the four active-low strobes (row strobe, column strobe, write strobe and output-enable strobe), which arrive already synchronised to a fast reference clock. It produces a driver-enable flag and a hold indication for the output data register.

Read data appears once a read access has started, and it is not withdrawn when the column strobe returns high. This lets the system latch data late in the column cycle. Read data keeps being driven until the output-enable or write strobe turns it off, or until a sticky high-impedance latch is armed. That latch is armed by either of two output-enable sequences around the column-strobe rising edge. Once armed, it ignores the output-enable strobe. It is released by the next column-strobe falling edge or by a full return to idle. Both outputs are registered and reflect the strobe levels sampled at the previous rising clock edge.

Top module: `edo_oe_ctrl`

## Requirements
- R1: During and just after reset, dq_oe is 0 and dout_hold is 1.
- R2: A read access begins when the column strobe falls while the row strobe is low and the write strobe is high. One clock later dq_oe is 1, provided the output-enable strobe is low.
- R3: While the row and column strobes are low in a read access, dq_oe follows the output-enable strobe one clock later: 1 when it is low, 0 when it is high.
- R4: A rising edge of the column strobe does not clear dq_oe. Read data stays driven while the output-enable strobe stays low and the write strobe stays high.
- R5: Suppose the output-enable strobe is high in the clock where the column-strobe rise is sampled, and stays high for HOLD_CYC further clocks with the column strobe still high. The sticky latch is then armed. If it goes low sooner, the latch is not armed.
- R6: Suppose the output-enable strobe was low when the column strobe rose. A later high pulse of at least PULSE_CYC clocks, inside the same column-high period, arms the sticky latch. A shorter pulse does not arm it.
- R7: While the sticky latch is armed and the column strobe stays high, dq_oe is 0 whatever the output-enable strobe does. The next column-strobe falling edge releases the latch.
- R8: A low write strobe forces dq_oe to 0 one clock later.
- R9: A column-strobe fall with the write strobe low marks a write access. dq_oe stays 0 for that whole access, even if the write strobe goes back high and the output-enable strobe is low.
- R10: When the row and column strobes are both high, dq_oe becomes 0, the stored read data is marked invalid and the sticky latch is cleared.
- R11: dout_hold is 0 (load the data register) only while the row and column strobes are both low in a read access. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, already synchronised |
| cas_n | input | 1 | Column strobe, active low, already synchronised |
| we_n | input | 1 | Write strobe, active low, already synchronised |
| oe_n | input | 1 | Output-enable strobe, active low, already synchronised |
| dq_oe | output | 1 | 1 when the data-pin drivers are enabled |
| dout_hold | output | 1 | 1 when the output data register keeps its value |

## Verification
The bench builds the block with HOLD_CYC = 3 and PULSE_CYC = 4. These differ from each other and from the defaults, so a mix-up between the two thresholds, or an off-by-one in either, shows up as a wrong dq_oe level. At each threshold the bench drives the output-enable high window one clock short and then exactly long enough. It also checks that an armed latch survives output-enable toggling and that a column-strobe fall or a return to idle releases it.

// File: rtl/edo_oe_pkg.sv
// Package: shared strobe type for the EDO output-enable controller.
// Assumes all strobes are already synchronised to the reference clock.
package edo_oe_pkg;

    // Strobes in asserted (active-high) form: 1 means the pin is low.
    typedef struct packed {
        logic row;
        logic col;
        logic wr;
        logic oe;
    } strobe_t;

    // Turn active-low pin levels into the asserted form.
    function automatic strobe_t to_asserted(input logic ras_n, input logic cas_n,
                                            input logic we_n, input logic oe_n);
        strobe_t s;
        s.row = ~ras_n;
        s.col = ~cas_n;
        s.wr  = ~we_n;
        s.oe  = ~oe_n;
        return s;
    endfunction

endpackage

// File: rtl/edo_strobe_edge.sv
// Column-strobe edge finder and idle detector.
// Produces the column assert/release events by comparing each sample with
// the previous one. Idle means the row and column strobes are both released.
module edo_strobe_edge
    import edo_oe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t strb,
    output logic    col_start,
    output logic    col_end,
    output logic    idle
);

    logic col_prev;

    // Remember the previous column-strobe level (released after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) col_prev <= 1'b0;
        else        col_prev <= strb.col;
    end

    // Decode edges and the idle condition.
    always_comb begin
        col_start = strb.col & ~col_prev;
        col_end   = ~strb.col & col_prev;
        idle      = ~strb.row & ~strb.col;
    end

endmodule

// File: rtl/edo_cycle_track.sv
// Access-type tracker.
// At each column-strobe fall it records whether the access reads or writes.
// The record is kept until the next fall, or until idle clears it.
// Exposes both next-state and registered values.
module edo_cycle_track
    import edo_oe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t strb,
    input  logic    col_start,
    input  logic    idle,
    output logic    rd_valid_nx,
    output logic    wr_cyc_nx,
    output logic    rd_valid_q,
    output logic    wr_cyc_q
);

    // Next access type from the current strobes.
    always_comb begin
        rd_valid_nx = rd_valid_q;
        wr_cyc_nx   = wr_cyc_q;
        if (idle) begin
            rd_valid_nx = 1'b0;
            wr_cyc_nx   = 1'b0;
        end else if (col_start) begin
            wr_cyc_nx   = strb.wr;
            rd_valid_nx = strb.row & ~strb.wr;
        end
    end

    // Register the access type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            wr_cyc_q   <= 1'b0;
        end else begin
            rd_valid_q <= rd_valid_nx;
            wr_cyc_q   <= wr_cyc_nx;
        end
    end

endmodule

// File: rtl/edo_hiz_latch.sv
// Sticky high-impedance latch.
// Counts consecutive column-high clocks with output-enable released.
// A run that starts at the column release must last HOLD_CYC more clocks;
// a run that starts later must last PULSE_CYC clocks. Either arms the latch.
// The latch is released at a column-strobe fall or at idle.
// Assumes HOLD_CYC >= 0 and PULSE_CYC >= 1.
module edo_hiz_latch
    import edo_oe_pkg::*;
#(
    parameter int HOLD_CYC  = 2,
    parameter int PULSE_CYC = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t strb,
    input  logic    col_start,
    input  logic    col_end,
    input  logic    idle,
    output logic    sticky_nx,
    output logic    sticky_q
);

    localparam int RISE_LIM = HOLD_CYC + 1;
    localparam int MAX_LIM  = (RISE_LIM > PULSE_CYC) ? RISE_LIM : PULSE_CYC;
    localparam int CNT_W    = $clog2(MAX_LIM + 2);
    localparam logic [CNT_W-1:0] RISE_LIM_C  = CNT_W'(RISE_LIM);
    localparam logic [CNT_W-1:0] PULSE_LIM_C = CNT_W'(PULSE_CYC);
    localparam logic [CNT_W-1:0] MAX_LIM_C   = CNT_W'(MAX_LIM);

    logic [CNT_W-1:0] run_q, run_nx;
    logic             from_end_q, from_end_nx;

    // Next run length, run origin and latch state.
    always_comb begin
        run_nx      = run_q;
        from_end_nx = from_end_q;
        sticky_nx   = sticky_q;
        if (idle) begin
            run_nx      = '0;
            from_end_nx = 1'b0;
            sticky_nx   = 1'b0;
        end else if (col_start) begin
            run_nx      = '0;
            from_end_nx = 1'b0;
            sticky_nx   = 1'b0;
        end else if (!strb.col && !strb.oe) begin
            if (col_end) begin
                run_nx      = CNT_W'(1);
                from_end_nx = 1'b1;
            end else if (run_q == '0) begin
                run_nx      = CNT_W'(1);
                from_end_nx = 1'b0;
            end else if (run_q < MAX_LIM_C) begin
                run_nx = run_q + CNT_W'(1);
            end
            if ((from_end_nx && run_nx >= RISE_LIM_C) ||
                (!from_end_nx && run_nx >= PULSE_LIM_C))
                sticky_nx = 1'b1;
        end else begin
            run_nx      = '0;
            from_end_nx = 1'b0;
        end
    end

    // Register run counter, origin flag and latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= '0;
            from_end_q <= 1'b0;
            sticky_q   <= 1'b0;
        end else begin
            run_q      <= run_nx;
            from_end_q <= from_end_nx;
            sticky_q   <= sticky_nx;
        end
    end

endmodule

// File: rtl/edo_oe_ctrl.sv
// EDO output-enable controller (top).
// Combines edge detection, access tracking and the sticky latch into
// registered driver-enable and data-hold outputs, one clock behind the
// sampled strobes. Assumes the strobes are synchronised to clk.
module edo_oe_ctrl #(
    parameter int HOLD_CYC  = 2,
    parameter int PULSE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic oe_n,
    output logic dq_oe,
    output logic dout_hold
);

    import edo_oe_pkg::*;

    strobe_t strb;
    logic    col_start, col_end, idle;
    logic    rd_valid_nx, wr_cyc_nx, rd_valid_q, wr_cyc_q;
    logic    hiz_sticky_nx, hiz_sticky;
    logic    drive_nx, hold_nx;

    // Convert pins to asserted form.
    always_comb strb = to_asserted(ras_n, cas_n, we_n, oe_n);

    edo_strobe_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb),
        .col_start (col_start),
        .col_end   (col_end),
        .idle      (idle)
    );

    edo_cycle_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb        (strb),
        .col_start   (col_start),
        .idle        (idle),
        .rd_valid_nx (rd_valid_nx),
        .wr_cyc_nx   (wr_cyc_nx),
        .rd_valid_q  (rd_valid_q),
        .wr_cyc_q    (wr_cyc_q)
    );

    edo_hiz_latch #(
        .HOLD_CYC  (HOLD_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb),
        .col_start (col_start),
        .col_end   (col_end),
        .idle      (idle),
        .sticky_nx (hiz_sticky_nx),
        .sticky_q  (hiz_sticky)
    );

    // Decide the next driver enable and data-register hold.
    always_comb begin
        drive_nx = rd_valid_nx & ~wr_cyc_nx & ~hiz_sticky_nx
                 & strb.oe & ~strb.wr & (strb.row | ~strb.col);
        hold_nx  = ~(strb.row & strb.col & rd_valid_nx & ~wr_cyc_nx);
    end

    // Register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe     <= 1'b0;
            dout_hold <= 1'b1;
        end else begin
            dq_oe     <= drive_nx;
            dout_hold <= hold_nx;
        end
    end

endmodule

// File: rtl/edo_oe_chk.sv
// Assertion checker for edo_oe_ctrl, bound to every instance below.
// Relates the strobe pins to the registered outputs and to the latch state.
module edo_oe_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic dout_hold,
    input logic hiz_sticky
);

    // R10: idle turns drivers off and clears the latch.
    p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n) |=> (!dq_oe && !hiz_sticky));

    // R3: a high output-enable strobe turns drivers off.
    p_oe_high_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dq_oe);

    // R8: a low write strobe turns drivers off.
    p_we_low_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dq_oe);

    // R4: data stays driven across a column-high period with OE low.
    p_edo_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && cas_n && !ras_n && !oe_n && we_n) |=> dq_oe);

    // R7: an armed latch keeps drivers off while the column strobe stays high.
    p_sticky_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_sticky && cas_n) |=> !dq_oe);

    // R7: a column-strobe fall releases the latch.
    p_fall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cas_n) && !cas_n) |=> !hiz_sticky);

    // R11: the data register loads only while both strobes are low.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n || cas_n) |=> dout_hold);

endmodule

bind edo_oe_ctrl edo_oe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .dq_oe      (dq_oe),
    .dout_hold  (dout_hold),
    .hiz_sticky (hiz_sticky)
);

// File: tb/edo_oe_ctrl_tb.sv
// Directed bench for edo_oe_ctrl: one task per scenario.
module edo_oe_ctrl_tb;

    localparam int HOLD  = 3;
    localparam int PULSE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic dq_oe, dout_hold;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    edo_oe_ctrl #(.HOLD_CYC(HOLD), .PULSE_CYC(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .dout_hold(dout_hold)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive strobes at the falling edge and settle after the next rising edge.
    task automatic step(input logic r, input logic c, input logic w, input logic o);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        @(posedge clk);
        #1;
    endtask

    // Go idle, then start a read access with OE low.
    task automatic open_read();
        step(1, 1, 1, 1);
        step(0, 1, 1, 1);
        step(0, 0, 1, 0);
    endtask

    task automatic t_reset();
        chk(dq_oe, 1'b0, "R1 dq_oe in reset");
        chk(dout_hold, 1'b1, "R1 dout_hold in reset");
    endtask

    task automatic t_read_oe();
        open_read();
        chk(dq_oe, 1'b1, "R2 read drives");
        chk(dout_hold, 1'b0, "R11 load during read");
        step(0, 0, 1, 1);
        chk(dq_oe, 1'b0, "R3 OE high off");
        step(0, 0, 1, 0);
        chk(dq_oe, 1'b1, "R3 OE low on again");
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b1, "R4 kept after column rise");
        chk(dout_hold, 1'b1, "R11 hold while column high");
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b1, "R4 still kept");
    endtask

    task automatic t_hold_method();
        open_read();
        step(0, 0, 1, 1);
        step(0, 1, 1, 1);
        for (int i = 0; i < HOLD - 1; i++) step(0, 1, 1, 1);
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b1, "R5 short hold leaves latch clear");
        step(0, 0, 1, 0);
        step(0, 0, 1, 1);
        step(0, 1, 1, 1);
        for (int i = 0; i < HOLD; i++) step(0, 1, 1, 1);
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b0, "R5 full hold arms latch");
        step(0, 1, 1, 1);
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b0, "R7 OE toggles ignored");
        step(0, 0, 1, 0);
        chk(dq_oe, 1'b1, "R7 column fall releases");
    endtask

    task automatic t_pulse_method();
        open_read();
        step(0, 1, 1, 0);
        for (int i = 0; i < PULSE - 1; i++) step(0, 1, 1, 1);
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b1, "R6 short pulse leaves latch clear");
        for (int i = 0; i < PULSE; i++) step(0, 1, 1, 1);
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b0, "R6 full pulse arms latch");
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b0, "R7 latch holds with OE low");
        step(1, 1, 1, 0);
        step(0, 1, 1, 0);
        step(0, 0, 1, 0);
        chk(dq_oe, 1'b1, "R10 idle cleared latch, new read drives");
    endtask

    task automatic t_write();
        open_read();
        step(0, 0, 0, 0);
        chk(dq_oe, 1'b0, "R8 W low forces off");
        step(0, 0, 1, 0);
        chk(dq_oe, 1'b1, "R8 W high restores read");
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 1, 0);
        chk(dq_oe, 1'b0, "R9 write access stays off");
        chk(dout_hold, 1'b1, "R11 no load in write access");
        step(0, 1, 1, 0);
        chk(dq_oe, 1'b0, "R9 off after column rise");
        step(1, 1, 1, 0);
        chk(dq_oe, 1'b0, "R10 idle off");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_read_oe();
        t_hold_method();
        t_pulse_method();
        t_write();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule